// File: doc/BRIEF.md
# I/O Page Mode Flag Bank

This block holds a set of single-bit machine mode flags that a processor controls through its 8-bit bus. The flags sit in the I/O page `0xC000`–`0xC0FF`. Each flag has its own address that clears it, its own address that sets it, and a third address where its state can be read. The block watches the 16-bit address and the read and write strobes. It updates the flags on the clock edge that ends the cycle and drives a read data byte during a read. It exports the whole flag vector to the memory banking and display logic.

The flags fall into two groups. Eight memory and display-option flags change only when the processor writes to their set or clear address. Four display-mode flags also change when the processor merely reads one of those addresses. A handful of further I/O locations that the system ignores are answered here with a zero byte. The block raises a claim signal for every cycle it decodes, so the bus fabric can tell handled cycles apart from unhandled ones.

Top module: `ssw_bank`

## Requirements
- R1: A synchronous active-high reset clears every flag to 0. While there is no access, `bus_claimed` is 0 and `bus_rdata` is 0x00.
- R2: A write to a flag's set address sets that flag, and a write to its clear address clears it. The change shows on `mode_flags` after the next rising clock edge, and the written data value has no effect. The bit positions and their addresses, given as clear/set/status, are:
  - bit0: C000/C001/C018
  - bit1: C002/C003/C013
  - bit2: C004/C005/C014
  - bit3: C006/C007/C015
  - bit4: C008/C009/C016
  - bit5: C00A/C00B/C017
  - bit6: C00C/C00D/C01F
  - bit7: C00E/C00F/C01E
  - bit8: C050/C051/C01A
  - bit9: C052/C053/C01B
  - bit10: C054/C055/C01C
  - bit11: C056/C057/C01D
- R3: A read of a status address is claimed. In the same cycle it returns 0x80 if the flag is 1 and 0x00 if the flag is 0.
- R4: For flags bit8 to bit11, a read of the set or clear address is claimed, returns 0xFF, and sets or clears the flag at the next edge.
- R5: For flags bit0 to bit7, a read of the set or clear address does not change any flag and is not claimed. In particular, a read of 0xC000 does not clear bit0, because that read belongs to another function.
- R6: Reads of 0xC058, 0xC05A, 0xC05D, 0xC05F, 0xC061 and 0xC062 are claimed, return 0x00 and change no flag.
- R7: Every access to an address this block does not decode leaves the flags unchanged, keeps `bus_claimed` at 0 and returns 0x00. This covers writes to status addresses, writes to the ignored read locations, and any address outside the page.
- R8: With neither strobe active, the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data (not used by any flag) |
| bus_rdata | output | 8 | Read data, combinational from address and flags |
| bus_claimed | output | 1 | High when this cycle's access is decoded here |
| mode_flags | output | 12 | Current flag vector, bit order as in R2 |

## Verification
The assertions assume that the read and write strobes are never active in the same cycle, because one bus cycle is either a read or a write. They also assume that the address is stable for the whole cycle in which a strobe is active. The stimulus chooses each cycle as one of three kinds: a read, a write or an idle cycle. It changes the address and strobes only on the falling clock edge. Most addresses come from the decoded part of the I/O page, and a small share come from the whole address space, so that the unclaimed paths are also exercised.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 12;
    localparam int NUM_MEM   = 8;   // flags below this index change on writes only
    localparam int OFF_W     = 8;
    localparam int PAGE_W    = ADDR_W - OFF_W;

    localparam logic [PAGE_W-1:0] IO_PAGE = 8'hC0;
    localparam logic [DATA_W-1:0] STS_ON  = 8'h80;
    localparam logic [DATA_W-1:0] STS_OFF = 8'h00;
    localparam logic [DATA_W-1:0] STROBE_RD = 8'hFF;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t set_hit;
        flag_vec_t clr_hit;
        flag_vec_t sts_hit;
        logic      quiet_hit;
    } dec_t;

    // clear offsets: memory flags pair up from 0x00, display flags from 0x50
    function automatic logic [OFF_W-1:0] clr_off(input int idx);
        if (idx < NUM_MEM) return OFF_W'(2 * idx);
        return OFF_W'(8'h50 + 2 * (idx - NUM_MEM));
    endfunction

    function automatic logic [OFF_W-1:0] set_off(input int idx);
        return clr_off(idx) | OFF_W'(1);
    endfunction

    function automatic logic [OFF_W-1:0] sts_off(input int idx);
        case (idx)
            0:  return 8'h18;
            1:  return 8'h13;
            2:  return 8'h14;
            3:  return 8'h15;
            4:  return 8'h16;
            5:  return 8'h17;
            6:  return 8'h1F;
            7:  return 8'h1E;
            8:  return 8'h1A;
            9:  return 8'h1B;
            10: return 8'h1C;
            default: return 8'h1D;
        endcase
    endfunction

    function automatic logic read_strobes(input int idx);
        return idx >= NUM_MEM;
    endfunction

    function automatic flag_vec_t read_strobe_mask();
        flag_vec_t m;
        for (int i = 0; i < NUM_FLAGS; i++) m[i] = read_strobes(i);
        return m;
    endfunction

    function automatic logic is_quiet(input logic [OFF_W-1:0] off);
        case (off)
            8'h58, 8'h5A, 8'h5D, 8'h5F, 8'h61, 8'h62: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ssw_decode.sv
module ssw_decode
    import ssw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output dec_t              dec
);
    logic              page_hit;
    logic [OFF_W-1:0]  off;

    assign page_hit = (addr[ADDR_W-1:OFF_W] == IO_PAGE);
    assign off      = addr[OFF_W-1:0];

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : gen_flag_dec
        localparam logic [OFF_W-1:0] L_CLR = clr_off(g);
        localparam logic [OFF_W-1:0] L_SET = set_off(g);
        localparam logic [OFF_W-1:0] L_STS = sts_off(g);
        localparam logic             L_RDS = read_strobes(g);

        logic strobe;
        assign strobe = wr | (rd & L_RDS);

        assign dec.set_hit[g] = page_hit & (off == L_SET) & strobe;
        assign dec.clr_hit[g] = page_hit & (off == L_CLR) & strobe;
        assign dec.sts_hit[g] = page_hit & (off == L_STS) & rd;
    end

    assign dec.quiet_hit = page_hit & rd & is_quiet(off);

endmodule

// File: rtl/ssw_flag_cell.sv
module ssw_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_hit,
    input  logic clr_hit,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_hit) q <= 1'b1;
        else if (clr_hit) q <= 1'b0;
    end
endmodule

// File: rtl/ssw_rdmux.sv
module ssw_rdmux
    import ssw_pkg::*;
(
    input  dec_t              dec,
    input  flag_vec_t         flags,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              claimed
);
    logic any_sts;
    logic any_strobe;
    logic sel_state;

    assign any_sts    = |dec.sts_hit;
    assign any_strobe = |(dec.set_hit | dec.clr_hit);
    assign sel_state  = |(dec.sts_hit & flags);

    always_comb begin
        if (any_sts)
            rdata = sel_state ? STS_ON : STS_OFF;
        else if (rd && any_strobe)
            rdata = STROBE_RD;
        else
            rdata = '0;
    end

    assign claimed = any_sts | any_strobe | dec.quiet_hit;
endmodule

// File: rtl/ssw_bank.sv
module ssw_bank
    import ssw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               bus_claimed,
    output logic [11:0]        mode_flags
);
    dec_t      dec;
    flag_vec_t flags;

    ssw_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : gen_cell
        ssw_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_hit (dec.set_hit[g]),
            .clr_hit (dec.clr_hit[g]),
            .q       (flags[g])
        );
    end

    ssw_rdmux u_mux (
        .dec     (dec),
        .flags   (flags),
        .rd      (bus_rd),
        .rdata   (bus_rdata),
        .claimed (bus_claimed)
    );

    assign mode_flags = flags;
endmodule

// File: rtl/ssw_bank_chk.sv
module ssw_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        bus_claimed,
    input logic [11:0] mode_flags
);
    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> mode_flags == 12'h000); // R1

    AST_WR_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr == 16'hC001 && bus_wdata == 8'h00) |=> mode_flags[0]); // R2

    AST_STS_BIT7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 16'hC01A) |-> (bus_claimed && bus_rdata == {mode_flags[8], 7'b0})); // R3

    AST_VID_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 16'hC054) |-> (bus_claimed && bus_rdata == 8'hFF)); // R4

    AST_VID_RD_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 16'hC057) |=> mode_flags[11]); // R4

    AST_MEM_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[15:4] == 12'hC00) |=> mode_flags[7:0] == $past(mode_flags[7:0])); // R5

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 16'hC05F) |-> (bus_claimed && bus_rdata == 8'h00)); // R6

    AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_claimed |-> bus_rdata == 8'h00); // R7

    AST_UNCLAIMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_claimed |=> $stable(mode_flags)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr) |=> $stable(mode_flags)); // R8

    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(mode_flags ^ $past(mode_flags)) <= 1); // R2
endmodule

bind ssw_bank ssw_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_claimed (bus_claimed),
    .mode_flags  (mode_flags)
);

// File: tb/ssw_bank_bench.sv
module ssw_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_claimed;
    logic [11:0] mode_flags;

    int checks = 0;
    int errors = 0;
    logic [11:0] model = 12'h000;

    always #5 clk = ~clk;

    ssw_bank u_ssw_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_claimed(bus_claimed),
        .mode_flags(mode_flags)
    );

    // kind: 0 none, 1 clear, 2 set, 3 status, 4 ignored-read location
    function automatic void lookup(input logic [15:0] a, output int bitn, output int kind);
        bitn = 0; kind = 0;
        case (a)
            16'hC000: begin bitn = 0;  kind = 1; end
            16'hC001: begin bitn = 0;  kind = 2; end
            16'hC018: begin bitn = 0;  kind = 3; end
            16'hC002: begin bitn = 1;  kind = 1; end
            16'hC003: begin bitn = 1;  kind = 2; end
            16'hC013: begin bitn = 1;  kind = 3; end
            16'hC004: begin bitn = 2;  kind = 1; end
            16'hC005: begin bitn = 2;  kind = 2; end
            16'hC014: begin bitn = 2;  kind = 3; end
            16'hC006: begin bitn = 3;  kind = 1; end
            16'hC007: begin bitn = 3;  kind = 2; end
            16'hC015: begin bitn = 3;  kind = 3; end
            16'hC008: begin bitn = 4;  kind = 1; end
            16'hC009: begin bitn = 4;  kind = 2; end
            16'hC016: begin bitn = 4;  kind = 3; end
            16'hC00A: begin bitn = 5;  kind = 1; end
            16'hC00B: begin bitn = 5;  kind = 2; end
            16'hC017: begin bitn = 5;  kind = 3; end
            16'hC00C: begin bitn = 6;  kind = 1; end
            16'hC00D: begin bitn = 6;  kind = 2; end
            16'hC01F: begin bitn = 6;  kind = 3; end
            16'hC00E: begin bitn = 7;  kind = 1; end
            16'hC00F: begin bitn = 7;  kind = 2; end
            16'hC01E: begin bitn = 7;  kind = 3; end
            16'hC050: begin bitn = 8;  kind = 1; end
            16'hC051: begin bitn = 8;  kind = 2; end
            16'hC01A: begin bitn = 8;  kind = 3; end
            16'hC052: begin bitn = 9;  kind = 1; end
            16'hC053: begin bitn = 9;  kind = 2; end
            16'hC01B: begin bitn = 9;  kind = 3; end
            16'hC054: begin bitn = 10; kind = 1; end
            16'hC055: begin bitn = 10; kind = 2; end
            16'hC01C: begin bitn = 10; kind = 3; end
            16'hC056: begin bitn = 11; kind = 1; end
            16'hC057: begin bitn = 11; kind = 2; end
            16'hC01D: begin bitn = 11; kind = 3; end
            16'hC058, 16'hC05A, 16'hC05D, 16'hC05F, 16'hC061, 16'hC062: kind = 4;
            default: kind = 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit r, input bit w,
                          input logic [7:0] d, input string tag);
        int bitn, kind;
        logic [7:0] exp_rd;
        logic exp_cl;
        logic [11:0] nxt;
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        lookup(a, bitn, kind);
        exp_rd = 8'h00; exp_cl = 1'b0; nxt = model;
        if (r) begin
            if (kind == 3) begin exp_cl = 1'b1; exp_rd = model[bitn] ? 8'h80 : 8'h00; end
            else if (kind == 4) exp_cl = 1'b1;
            else if ((kind == 1 || kind == 2) && bitn >= 8) begin
                exp_cl = 1'b1; exp_rd = 8'hFF; nxt[bitn] = (kind == 2);
            end
        end else if (w) begin
            if (kind == 1 || kind == 2) begin exp_cl = 1'b1; nxt[bitn] = (kind == 2); end
        end
        #1;
        check({tag, " rdata"}, {8'h00, bus_rdata}, {8'h00, exp_rd});
        check({tag, " claimed"}, {15'h0, bus_claimed}, {15'h0, exp_cl});
        @(posedge clk);
        #1;
        model = nxt;
        check({tag, " flags"}, {4'h0, mode_flags}, {4'h0, model});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 reset flags", {4'h0, mode_flags}, 16'h0000);
        check("R1 idle claimed", {15'h0, bus_claimed}, 16'h0000);
        check("R1 idle rdata", {8'h0, bus_rdata}, 16'h0000);

        access(16'hC001, 0, 1, 8'h00, "R2 set bit0 data 00");
        access(16'hC000, 1, 0, 8'h00, "R5 read C000 keeps bit0");
        access(16'hC018, 1, 0, 8'h00, "R3 status bit0 on");
        access(16'hC00D, 1, 0, 8'h00, "R5 read set addr bit6");
        access(16'hC01F, 1, 0, 8'h00, "R3 status bit6 off");
        access(16'hC00D, 0, 1, 8'h5A, "R2 set bit6");
        access(16'hC00C, 0, 1, 8'hFF, "R2 clear bit6 data FF");
        access(16'hC051, 1, 0, 8'h00, "R4 read sets bit8");
        access(16'hC01A, 1, 0, 8'h00, "R3 status bit8 on");
        access(16'hC050, 1, 0, 8'h00, "R4 read clears bit8");
        access(16'hC055, 0, 1, 8'h11, "R4 write sets bit10");
        access(16'hC05D, 1, 0, 8'h00, "R6 ignored read");
        access(16'hC062, 1, 0, 8'h00, "R6 ignored read");
        access(16'hC05D, 0, 1, 8'h33, "R7 write to ignored loc");
        access(16'hC018, 0, 1, 8'h00, "R7 write to status addr");
        access(16'hC0FF, 1, 0, 8'h00, "R7 unmapped read");
        access(16'hD001, 0, 1, 8'h00, "R7 off-page write");
        access(16'h0000, 0, 0, 8'h00, "R8 idle hold");

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int op;
            if ($urandom % 10 == 0) a = 16'($urandom);
            else a = 16'hC000 + 16'($urandom % 16'h68);
            op = int'($urandom % 3);
            access(a, op == 1, op == 2, 8'($urandom), "R2-rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule